// File: doc/BRIEF.md
# Vector Memory Address Sequencer

This block turns one vector memory command into the stream of byte addresses, one per element, that a load/store pipe presents to memory. A command carries a base address, an element size code, an addressing mode, a signed element stride and a vector length. The block accepts it through a valid/ready pair. It then emits one address per clock through a second valid/ready pair, flags the final element and pulses a completion strobe.

Three access patterns are covered. Consecutive elements can sit back to back. They can sit a constant signed number of elements apart. They can sit at per-element offsets that arrive on an index stream, which gives gather/scatter. All strides and offsets count elements, not bytes, and the block scales them by the element size. Address arithmetic wraps modulo 2^ADDR_W. A zero length completes without emitting anything. A length above the maximum is clamped to the maximum.

Top module: `vmem_addr_gen`

## Requirements
- R1: With cmdMode = 0 (contiguous), element i is emitted at cmdBase + i * 2^cmdSize, where cmdSize codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 byte elements.
- R2: With cmdMode = 1 (strided), element i is emitted at cmdBase + i * cmdStride * 2^cmdSize. The stride is read as signed two's complement and the sum wraps modulo 2^32.
- R3: With cmdMode = 2 (indexed), element i is emitted at cmdBase + idxData_i * 2^cmdSize, where idxData_i is the i-th accepted signed index. An index is consumed only in a cycle with idxValid, idxReady, addrValid and addrReady all high, and idxReady stays low in the other modes.
- R4: A command of length L (1 to MAX_VL) produces exactly L address handshakes, and addrLast is high on the final one only.
- R5: A command with length 0 produces no address, and done is high in the cycle after the command is accepted.
- R6: While addrValid is high and addrReady is low, addrValid, addrData and addrLast keep their values into the next cycle.
- R7: cmdReady is low while a command is in progress, and done is high for the cycle after the final address handshake.
- R8: While rstN is low, addrValid, done and idxReady are low and cmdReady is high.
- R9: cmdMode = 3 behaves exactly like the contiguous mode.
- R10: A cmdLen above MAX_VL is treated as MAX_VL (64 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Sequencer idle, command taken when both are high |
| cmdMode | input | 2 | 0 contiguous, 1 strided, 2 indexed, 3 contiguous |
| cmdSize | input | 2 | log2 of element bytes |
| cmdBase | input | ADDR_W | Byte base address |
| cmdStride | input | ADDR_W | Signed stride in elements |
| cmdLen | input | LEN_W | Vector length, clamped to MAX_VL |
| idxValid | input | 1 | Index element offered |
| idxReady | output | 1 | Index element taken when both are high |
| idxData | input | ADDR_W | Signed element offset |
| addrValid | output | 1 | Address offered |
| addrReady | input | 1 | Consumer takes the address |
| addrData | output | ADDR_W | Byte address |
| addrLast | output | 1 | Address belongs to the final element |
| done | output | 1 | One-cycle completion strobe |

## Verification
The bound checker watches several things on every cycle. It checks that a stalled address holds, and that the index stream only moves with an address handshake. It checks that commands are refused while busy, and that addrLast lines up with the element count the checker tracks itself. It also checks the completion strobe after the last element or after a zero-length command, and the fixed step between successive contiguous addresses. The absolute address values are shown only by the bench's scenarios. These cover strided and indexed arithmetic with negative and wrapping offsets, all four element sizes, the reserved mode code and length clamping. They are run under random back-pressure and index gaps.

// File: rtl/vagen_pkg.sv
package vagen_pkg;

  typedef enum logic [1:0] {
    MODE_UNIT   = 2'd0,
    MODE_STRIDE = 2'd1,
    MODE_INDEX  = 2'd2,
    MODE_RSVD   = 2'd3
  } agenMode_e;

  // strobes from the sequencing control to the address datapath
  typedef struct packed {
    logic load;     // latch a new command this cycle
    logic advance;  // an element address was taken this cycle
    logic stride;   // valid with load: step uses the command stride
    logic indexed;  // held for the command: address built from the index stream
  } agenStrobe_t;

endpackage

// File: rtl/agen_ctrl.sv
module agen_ctrl
  import vagen_pkg::*;
#(
  parameter int MAX_VL = 64,
  parameter int LEN_W  = $clog2(MAX_VL + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [1:0]       cmdMode,
  input  logic [LEN_W-1:0] cmdLen,
  input  logic             idxValid,
  input  logic             addrReady,
  output logic             cmdReady,
  output logic             addrValid,
  output logic             addrLast,
  output logic             idxReady,
  output logic             done,
  output agenStrobe_t      strobe
);

  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(MAX_VL);
  localparam logic [LEN_W-1:0] ONE     = LEN_W'(1);

  logic             busy;
  logic             idxMode;
  logic             doneQ;
  logic [LEN_W-1:0] elemCnt;
  logic [LEN_W-1:0] lastCnt;
  logic [LEN_W-1:0] effLen;
  logic             accept;
  logic             fire;

  assign effLen    = (cmdLen > MAX_LEN) ? MAX_LEN : cmdLen;
  assign cmdReady  = !busy;
  assign accept    = cmdValid && !busy;
  assign addrValid = busy && (idxMode ? idxValid : 1'b1);
  assign fire      = addrValid && addrReady;
  assign addrLast  = busy && (elemCnt == lastCnt);
  assign idxReady  = busy && idxMode && addrReady;
  assign done      = doneQ;

  always_comb begin
    strobe         = '0;
    strobe.load    = accept;
    strobe.advance = fire;
    strobe.stride  = (cmdMode == MODE_STRIDE);
    strobe.indexed = idxMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      idxMode <= 1'b0;
      doneQ   <= 1'b0;
      elemCnt <= '0;
      lastCnt <= '0;
    end else begin
      doneQ <= 1'b0;
      if (accept) begin
        if (effLen == '0) begin
          doneQ <= 1'b1;
        end else begin
          busy    <= 1'b1;
          elemCnt <= '0;
          lastCnt <= effLen - ONE;
          idxMode <= (cmdMode == MODE_INDEX);
        end
      end
      if (fire) begin
        elemCnt <= elemCnt + ONE;
        if (addrLast) begin
          busy    <= 1'b0;
          idxMode <= 1'b0;
          doneQ   <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/agen_datapath.sv
module agen_datapath
  import vagen_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  agenStrobe_t       strobe,
  input  logic [ADDR_W-1:0] cmdBase,
  input  logic [ADDR_W-1:0] cmdStride,
  input  logic [1:0]        cmdSize,
  input  logic [ADDR_W-1:0] idxData,
  output logic [ADDR_W-1:0] addrData
);

  localparam logic [ADDR_W-1:0] UNIT_ELEM = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] baseQ;
  logic [ADDR_W-1:0] stepQ;
  logic [ADDR_W-1:0] cursorQ;
  logic [1:0]        sizeQ;
  logic [ADDR_W-1:0] stepNext;
  logic [ADDR_W-1:0] idxBytes;

  // element counts become byte counts by a shift of log2(element bytes)
  assign stepNext = strobe.stride ? (cmdStride << cmdSize) : (UNIT_ELEM << cmdSize);
  assign idxBytes = idxData << sizeQ;
  assign addrData = strobe.indexed ? (baseQ + idxBytes) : cursorQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ   <= '0;
      stepQ   <= '0;
      cursorQ <= '0;
      sizeQ   <= '0;
    end else if (strobe.load) begin
      baseQ   <= cmdBase;
      cursorQ <= cmdBase;
      stepQ   <= stepNext;
      sizeQ   <= cmdSize;
    end else if (strobe.advance) begin
      cursorQ <= cursorQ + stepQ;
    end
  end

endmodule

// File: rtl/vmem_addr_gen.sv
module vmem_addr_gen
  import vagen_pkg::*;
#(
  parameter  int ADDR_W = 32,
  parameter  int MAX_VL = 64,
  localparam int LEN_W  = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [1:0]        cmdMode,
  input  logic [1:0]        cmdSize,
  input  logic [ADDR_W-1:0] cmdBase,
  input  logic [ADDR_W-1:0] cmdStride,
  input  logic [LEN_W-1:0]  cmdLen,
  input  logic              idxValid,
  output logic              idxReady,
  input  logic [ADDR_W-1:0] idxData,
  output logic              addrValid,
  input  logic              addrReady,
  output logic [ADDR_W-1:0] addrData,
  output logic              addrLast,
  output logic              done
);

  agenStrobe_t strobe;

  agen_ctrl #(.MAX_VL(MAX_VL), .LEN_W(LEN_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdMode  (cmdMode),
    .cmdLen   (cmdLen),
    .idxValid (idxValid),
    .addrReady(addrReady),
    .cmdReady (cmdReady),
    .addrValid(addrValid),
    .addrLast (addrLast),
    .idxReady (idxReady),
    .done     (done),
    .strobe   (strobe)
  );

  agen_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cmdBase  (cmdBase),
    .cmdStride(cmdStride),
    .cmdSize  (cmdSize),
    .idxData  (idxData),
    .addrData (addrData)
  );

endmodule

// File: rtl/vmem_addr_gen_chk.sv
module vmem_addr_gen_chk #(
  parameter  int ADDR_W = 32,
  parameter  int MAX_VL = 64,
  localparam int LEN_W  = $clog2(MAX_VL + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic [1:0]        cmdMode,
  input logic [1:0]        cmdSize,
  input logic [LEN_W-1:0]  cmdLen,
  input logic              idxValid,
  input logic              idxReady,
  input logic              addrValid,
  input logic              addrReady,
  input logic [ADDR_W-1:0] addrData,
  input logic              addrLast,
  input logic              done
);

  localparam logic [LEN_W-1:0]  MAX_LEN = LEN_W'(MAX_VL);
  localparam logic [LEN_W-1:0]  ONE     = LEN_W'(1);
  localparam logic [ADDR_W-1:0] UNIT_B  = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic              accept;
  logic              fire;
  logic [1:0]        seenMode;
  logic [1:0]        seenSize;
  logic [LEN_W-1:0]  seenLen;
  logic [LEN_W-1:0]  seenCnt;
  logic [ADDR_W-1:0] prevAddr;

  assign accept = cmdValid && cmdReady;
  assign fire   = addrValid && addrReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenMode <= '0;
      seenSize <= '0;
      seenLen  <= '0;
      seenCnt  <= '0;
      prevAddr <= '0;
    end else begin
      if (accept) begin
        seenMode <= cmdMode;
        seenSize <= cmdSize;
        seenLen  <= (cmdLen > MAX_LEN) ? MAX_LEN : cmdLen;
        seenCnt  <= '0;
      end
      if (fire) begin
        seenCnt  <= seenCnt + ONE;
        prevAddr <= addrData;
      end
    end
  end

  always @(posedge clk) begin
    if (!rstN) begin
      AST_RESET_QUIET: assert (!addrValid && !done && !idxReady && cmdReady); // R8
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    addrValid && !addrReady |=> addrValid && $stable(addrData) && $stable(addrLast)); // R6

  AST_IDX_WITH_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    idxValid && idxReady |-> addrValid && addrReady); // R3

  AST_BUSY_NO_CMD: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |-> !cmdReady); // R7

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    addrValid && addrReady && addrLast |=> done && !addrValid); // R7

  AST_LAST_POSITION: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |-> (addrLast == (seenCnt == seenLen - ONE))); // R4

  AST_ZERO_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    accept && (cmdLen == '0) |=> done && !addrValid); // R5

  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    fire && (seenCnt != '0) && (seenMode == 2'd0 || seenMode == 2'd3)
      |-> addrData == prevAddr + (UNIT_B << seenSize)); // R1 R9

endmodule

bind vmem_addr_gen vmem_addr_gen_chk #(.ADDR_W(ADDR_W), .MAX_VL(MAX_VL)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cmdValid (cmdValid),
  .cmdReady (cmdReady),
  .cmdMode  (cmdMode),
  .cmdSize  (cmdSize),
  .cmdLen   (cmdLen),
  .idxValid (idxValid),
  .idxReady (idxReady),
  .addrValid(addrValid),
  .addrReady(addrReady),
  .addrData (addrData),
  .addrLast (addrLast),
  .done     (done)
);

// File: tb/vmem_addr_gen_test.sv
module vmem_addr_gen_test;

  localparam int CLK_NS = 8;  // 125 MHz
  localparam int MAXV   = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [1:0]  cmdMode = '0;
  logic [1:0]  cmdSize = '0;
  logic [31:0] cmdBase = '0;
  logic [31:0] cmdStride = '0;
  logic [6:0]  cmdLen = '0;
  logic        idxValid = 1'b0;
  logic        idxReady;
  logic [31:0] idxData = '0;
  logic        addrValid;
  logic        addrReady = 1'b0;
  logic [31:0] addrData;
  logic        addrLast;
  logic        done;

  int nChecks = 0;
  int nFails  = 0;
  logic [31:0] idxArr [MAXV];

  always #(CLK_NS/2) clk = ~clk;

  vmem_addr_gen uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdMode(cmdMode), .cmdSize(cmdSize), .cmdBase(cmdBase), .cmdStride(cmdStride),
    .cmdLen(cmdLen), .idxValid(idxValid), .idxReady(idxReady), .idxData(idxData),
    .addrValid(addrValid), .addrReady(addrReady), .addrData(addrData),
    .addrLast(addrLast), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expAddr(input int mode, input int size,
      input logic [31:0] base, input logic [31:0] stride, input logic [31:0] idx, input int i);
    case (mode)
      1:       return base + ((stride * 32'(i)) << size);
      2:       return base + (idx << size);
      default: return base + (32'(i) << size);
    endcase
  endfunction

  function automatic string modeReq(input int mode);
    case (mode)
      1: return "R2";
      2: return "R3";
      3: return "R9";
      default: return "R1";
    endcase
  endfunction

  // readyPct: chance of addrReady per cycle; idxPct: chance an index is offered
  task automatic runCmd(input int mode, input int size, input logic [31:0] base,
                        input logic [31:0] stride, input int len,
                        input int readyPct, input int idxPct);
    int effLen;
    int k;
    int guard;
    bit idxHeld;
    bit wasStalled;
    logic [31:0] stallAddr;
    logic stallLast;
    string req;
    effLen = (len > MAXV) ? MAXV : len;
    req = modeReq(mode);
    for (int j = 0; j < MAXV; j++) idxArr[j] = $urandom;
    @(negedge clk);
    cmdValid = 1'b1; cmdMode = 2'(mode); cmdSize = 2'(size);
    cmdBase = base; cmdStride = stride; cmdLen = 7'(len);
    #3;
    check(cmdReady == 1'b1, "R7", "cmdReady when idle", cmdReady, 1);
    @(negedge clk);
    cmdValid = 1'b0;
    if (effLen == 0) begin
      check(done == 1'b1, "R5", "done after empty command", done, 1);
      check(addrValid == 1'b0, "R5", "no address for empty command", addrValid, 0);
      @(negedge clk);
      check(done == 1'b0, "R5", "done drops", done, 0);
      return;
    end
    k = 0; guard = 0; idxHeld = 1'b0; wasStalled = 1'b0;
    stallAddr = '0; stallLast = 1'b0;
    while (k < effLen && guard < 5000) begin
      guard++;
      addrReady = (($urandom % 100) < readyPct);
      if (!idxHeld) idxValid = (($urandom % 100) < idxPct);
      idxData = (mode == 2) ? idxArr[k] : $urandom;
      #3;
      if (k == 0 || (k % 16) == 5)
        check(cmdReady == 1'b0, "R7", "cmdReady while busy", cmdReady, 0);
      if (mode != 2)
        check(idxReady == 1'b0, "R3", "idxReady outside indexed mode", idxReady, 0);
      if (wasStalled) begin
        check(addrValid == 1'b1, "R6", "valid held in stall", addrValid, 1);
        check(addrData == stallAddr, "R6", "address held in stall", addrData, stallAddr);
        check(addrLast == stallLast, "R6", "last held in stall", addrLast, stallLast);
      end
      wasStalled = 1'b0;
      if (mode == 2 && !idxValid)
        check(addrValid == 1'b0, "R3", "no address without index", addrValid, 0);
      if (addrValid) begin
        if (addrReady) begin
          check(addrData == expAddr(mode, size, base, stride, idxArr[k], k), req,
                $sformatf("address of element %0d", k), addrData,
                expAddr(mode, size, base, stride, idxArr[k], k));
          check(addrLast == (k == effLen - 1), "R4", $sformatf("last flag at element %0d", k),
                addrLast, (k == effLen - 1));
          if (mode == 2)
            check(idxReady == 1'b1, "R3", "index taken with address", idxReady, 1);
          k++;
          idxHeld = 1'b0;
        end else begin
          wasStalled = 1'b1;
          stallAddr = addrData;
          stallLast = addrLast;
          if (mode == 2) idxHeld = 1'b1;
        end
      end
      @(negedge clk);
    end
    addrReady = 1'b0;
    idxValid = 1'b0;
    idxHeld = 1'b0;
    check(k == effLen, "R4", "address count", k, effLen);
    check(done == 1'b1, "R7", "done after final address", done, 1);
    check(addrValid == 1'b0, "R4", "no address beyond length", addrValid, 0);
    check(cmdReady == 1'b1, "R7", "idle after completion", cmdReady, 1);
  endtask

  initial begin
    #(CLK_NS * 190000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check(addrValid == 1'b0, "R8", "addrValid in reset", addrValid, 0);
    check(done == 1'b0, "R8", "done in reset", done, 0);
    check(idxReady == 1'b0, "R8", "idxReady in reset", idxReady, 0);
    check(cmdReady == 1'b1, "R8", "cmdReady in reset", cmdReady, 1);
    rstN = 1'b1;
    @(negedge clk);

    // directed corner cases
    runCmd(0, 2, 32'h0000_1000, 32'd0, 5, 100, 50);            // R1 words, no stall
    runCmd(0, 0, 32'hFFFF_FFFE, 32'd0, 4, 60, 50);             // R1 bytes, wrap
    runCmd(1, 3, 32'h0000_0010, 32'hFFFF_FFFF, 6, 70, 50);     // R2 negative stride, wrap
    runCmd(1, 1, 32'h8000_0000, 32'd7, 9, 40, 50);             // R2 positive stride, stalls
    runCmd(2, 2, 32'h0001_0000, 32'd0, 12, 70, 60);            // R3 gather with gaps
    runCmd(3, 3, 32'h0000_2000, 32'd99, 7, 80, 50);            // R9 reserved mode
    runCmd(1, 2, 32'h0000_4000, 32'd3, 0, 80, 50);             // R5 empty command
    runCmd(0, 1, 32'h0000_3000, 32'd0, 100, 80, 50);           // R10 clamp to 64
    runCmd(2, 0, 32'h0000_0100, 32'd0, 1, 30, 30);             // R4 single element
    runCmd(1, 0, 32'h0000_5000, 32'd0, 3, 90, 50);             // R2 zero stride

    // constrained random commands
    for (int n = 0; n < 60; n++) begin
      int m = $urandom % 4;
      int s = $urandom % 4;
      int l = $urandom % 80;
      logic [31:0] st = 32'($signed($urandom % 257) - 128);
      runCmd(m, s, $urandom, st, l, 40 + ($urandom % 61), 40 + ($urandom % 61));
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule